// File: doc/BRIEF.md
# Two-Channel Prescaled Interval Timer

The block holds two independent interval timers behind one small synchronous register port. A single free-running prescaler divides the system clock into four enable pulse rates: one pulse every 8, 32, 128 or 512 cycles. Each channel picks one of these rates and counts up on it while its bit in the shared start register is set. The count runs from zero up to a programmable compare constant. On the tick that finds the count equal to the constant, the counter wraps back to zero and the channel's sticky match flag is set. The timer period is therefore (constant + 1) ticks.

Each channel has its own interrupt request output, which is the level of the match flag gated by the channel's interrupt-enable bit. Software clears a flag with a two-step protocol. It first reads the control word while the flag is set, and only a later write of 0 to the flag bit then clears it. A standby input holds both counters and the prescaler at zero for as long as it is high. All logic runs in one clock domain.

Top module: `ivl_timer`

## Requirements
- R1: After reset the start register reads 0, both control words read 0 (rate select 00), both counters read 0x0000 and both compare constants read 0xFFFF.
- R2: Register address 0 is the start register; bit c enables channel c. A channel whose start bit is 0 keeps its count unchanged.
- R3: Rate select 00, 01, 10, 11 gives a count tick every 8, 32, 128, 512 clocks. The tick falls on the last cycle of each such group, counted from reset or from the end of standby. A started channel adds one to its count on each tick.
- R4: On a tick where the count equals the compare constant, the count becomes 0x0000 instead of incrementing, and the match flag becomes 1.
- R5: Channel c uses address 1+3c for its control word, 2+3c for its counter and 3+3c for its compare constant. Addresses 7 and above read 0. Control word fields: bit 7 is the match flag, bit 6 is the interrupt enable, bits 1:0 are the rate select. Bits 5:2 and 15:8 always read 0 and ignore writes.
- R6: Writing 1 to the flag bit has no effect. Writing 0 clears the flag only if that control word was read with the flag at 1 since the flag was last cleared. A match in the same cycle as a clearing write leaves the flag at 1.
- R7: irq[c] is high exactly while channel c's flag and interrupt enable are both 1.
- R8: Counter and compare registers can be written at any time. A counter write in the same cycle as an increment or a match wrap wins, and the written value is stored.
- R9: While standby is high, both counters and the prescaler are held at zero. All other registers keep their values.
- R10: The two channels are independent. Rate, constant, flag, enable and interrupt of one channel never depend on the other's settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rstN | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Holds counters and prescaler at zero while high |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe; arms the flag-clear protocol |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr, combinational |
| irq | output | 2 | Per-channel compare-match interrupt request |

## Verification
Two pairs of events can fall in the same clock edge. A software counter write can meet a count tick, and a flag-clearing write can meet a compare match. The bench follows the prescaler phase in its reference model and issues each write so that it lands on the edge where the model predicts a tick. For the flag case, the counter is first loaded to equal the constant, so the tick is also a match. The outcome is judged by reading back the written count, and by the flag still reading 1 after a clearing write that landed on a match. A per-cycle comparison against the model covers every other edge.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  // number of prescaled rates a channel may select from
  localparam int RATE_CNT = 4;
  localparam int SEL_W    = $clog2(RATE_CNT);

  // control word field positions
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;

  // strobes handed from the control to the datapath, one set per channel
  typedef struct packed {
    logic tick;     // gated count enable for this edge
    logic cntWr;    // software write of the counter
    logic cmpWr;    // software write of the compare constant
    logic flagClr;  // qualified clear of the match flag
  } chStrobe_t;

endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int CNT_W        = 16,
  parameter int DIV_BASE_LOG = 3,
  parameter int DIV_STEP_LOG = 2,
  localparam int ADDR_W      = $clog2(3 * NUM_CH + 1),
  localparam int PRE_W       = DIV_BASE_LOG + (RATE_CNT - 1) * DIV_STEP_LOG
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             standby,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic                             regWr,
  input  logic                             regRd,
  input  logic [CNT_W-1:0]                 regWdata,
  input  logic [NUM_CH-1:0]                flagQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     countQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cmpQ,
  output logic [CNT_W-1:0]                 regRdata,
  output chStrobe_t [NUM_CH-1:0]           strb,
  output logic [NUM_CH-1:0]                ieQ,
  output logic [RATE_CNT-1:0]              rateTick
);

  logic [PRE_W-1:0]             preCnt;
  logic [NUM_CH-1:0]            startQ;
  logic [NUM_CH-1:0][SEL_W-1:0] selQ;

  // shared free-running prescaler, held at zero in standby
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (standby) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  // one pulse per rate on the last cycle of each group
  for (genvar k = 0; k < RATE_CNT; k++) begin : g_rate
    localparam int LOGD = DIV_BASE_LOG + k * DIV_STEP_LOG;
    assign rateTick[k] = &preCnt[LOGD-1:0];
  end

  // shared start register at address 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         startQ <= '0;
    else if (regWr && regAddr == '0)   startQ <= regWdata[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(1 + 3 * c);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(2 + 3 * c);
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(3 + 3 * c);

    logic [SEL_W-1:0] selR;
    logic             ieR;
    logic             armR;
    logic             csrHit;
    logic             clrNow;

    assign csrHit = (regAddr == A_CSR);
    assign clrNow = regWr && csrHit && !regWdata[FLAG_BIT] && armR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selR <= '0;
        ieR  <= 1'b0;
      end else if (regWr && csrHit) begin
        selR <= regWdata[SEL_W-1:0];
        ieR  <= regWdata[IE_BIT];
      end
    end

    // read-then-write protocol for clearing the flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              armR <= 1'b0;
      else if (clrNow)                        armR <= 1'b0;
      else if (regRd && csrHit && flagQ[c])   armR <= 1'b1;
    end

    assign selQ[c] = selR;
    assign ieQ[c]  = ieR;
    assign strb[c] = '{tick:    startQ[c] && rateTick[selR],
                       cntWr:   regWr && (regAddr == A_CNT),
                       cmpWr:   regWr && (regAddr == A_CMP),
                       flagClr: clrNow};
  end

  // combinational read multiplexer
  always_comb begin
    regRdata = '0;
    if (regAddr == '0) regRdata[NUM_CH-1:0] = startQ;
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == ADDR_W'(1 + 3 * c)) begin
        regRdata[FLAG_BIT]  = flagQ[c];
        regRdata[IE_BIT]    = ieQ[c];
        regRdata[SEL_W-1:0] = selQ[c];
      end
      if (regAddr == ADDR_W'(2 + 3 * c)) regRdata = countQ[c];
      if (regAddr == ADDR_W'(3 + 3 * c)) regRdata = cmpQ[c];
    end
  end

endmodule

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         standby,
  input  chStrobe_t [NUM_CH-1:0]       strb,
  input  logic [CNT_W-1:0]             regWdata,
  output logic [NUM_CH-1:0][CNT_W-1:0] countQ,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmpQ,
  output logic [NUM_CH-1:0]            flagQ
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] cntR;
    logic [CNT_W-1:0] cmpR;
    logic             flagR;
    logic             hit;

    // a match is only taken on a count tick
    assign hit = strb[c].tick && (cntR == cmpR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cntR <= '0;
      else if (standby)        cntR <= '0;
      else if (strb[c].cntWr)  cntR <= regWdata;
      else if (hit)            cntR <= '0;
      else if (strb[c].tick)   cntR <= cntR + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cmpR <= '1;
      else if (strb[c].cmpWr)  cmpR <= regWdata;
    end

    // set beats clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 flagR <= 1'b0;
      else if (hit)              flagR <= 1'b1;
      else if (strb[c].flagClr)  flagR <= 1'b0;
    end

    assign countQ[c] = cntR;
    assign cmpQ[c]   = cmpR;
    assign flagQ[c]  = flagR;
  end

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int CNT_W        = 16,
  parameter int DIV_BASE_LOG = 3,
  parameter int DIV_STEP_LOG = 2,
  localparam int ADDR_W      = $clog2(3 * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic [NUM_CH-1:0] irq
);

  chStrobe_t [NUM_CH-1:0]       strb;
  logic [NUM_CH-1:0][CNT_W-1:0] countQ;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpQ;
  logic [NUM_CH-1:0]            flagQ;
  logic [NUM_CH-1:0]            ieQ;
  logic [RATE_CNT-1:0]          rateTick;

  ivl_timer_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W),
    .DIV_BASE_LOG(DIV_BASE_LOG), .DIV_STEP_LOG(DIV_STEP_LOG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .flagQ(flagQ), .countQ(countQ), .cmpQ(cmpQ),
    .regRdata(regRdata), .strb(strb), .ieQ(ieQ), .rateTick(rateTick)
  );

  ivl_timer_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .standby(standby),
    .strb(strb), .regWdata(regWdata),
    .countQ(countQ), .cmpQ(cmpQ), .flagQ(flagQ)
  );

  assign irq = flagQ & ieQ;

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         standby,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [CNT_W-1:0]             regWdata,
  input logic [CNT_W-1:0]             regRdata,
  input logic [NUM_CH-1:0]            irq,
  input chStrobe_t [NUM_CH-1:0]       strb,
  input logic [NUM_CH-1:0][CNT_W-1:0] countQ,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmpQ,
  input logic [NUM_CH-1:0]            flagQ,
  input logic [RATE_CNT-1:0]          rateTick
);

  // a slower rate pulse always coincides with every faster one (R3)
  for (genvar k = 0; k + 1 < RATE_CNT; k++) begin : g_rate
    p_rate_nested_r3: assert property (@(posedge clk) disable iff (!rstN)
      rateTick[k+1] |-> rateTick[k]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[c].tick && !strb[c].cntWr && !standby) |=> $stable(countQ[c]));

    p_match_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].tick && !strb[c].cntWr && !standby && countQ[c] == cmpQ[c])
        |=> (countQ[c] == '0 && flagQ[c]));

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
      (regAddr == ADDR_W'(1 + 3 * c)) |-> (regRdata[5:2] == '0 && regRdata[CNT_W-1:8] == '0));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[c] && !strb[c].flagClr) |=> flagQ[c]);

    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].flagClr && strb[c].tick && countQ[c] == cmpQ[c]) |=> flagQ[c]);

    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
      !flagQ[c] |-> !irq[c]);

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].cntWr && !standby) |=> countQ[c] == $past(regWdata));

    p_standby_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
      standby |=> countQ[c] == '0);
  end

endmodule

bind ivl_timer ivl_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .strb(strb),
  .countQ(countQ), .cmpQ(cmpQ), .flagQ(flagQ), .rateTick(rateTick)
);

// File: tb/ivl_timer_test.sv
module ivl_timer_test;

  logic        clk = 1'b0;
  logic        rstN, standby, regWr, regRd;
  logic [2:0]  regAddr;
  logic [15:0] regWdata, regRdata;
  logic [1:0]  irq;

  always #5 clk = ~clk;

  ivl_timer uut (
    .clk(clk), .rstN(rstN), .standby(standby), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit running = 1'b1;

  // behavioural reference model
  int mCnt[2], mCmp[2], mFlag[2], mIe[2], mSel[2], mArm[2], mStart[2];
  int mPre;

  always @(posedge clk) begin : model
    int tk[2];
    int div, base, match, clr;
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mCnt[c] = 0; mCmp[c] = 65535; mFlag[c] = 0; mIe[c] = 0;
        mSel[c] = 0; mArm[c] = 0; mStart[c] = 0;
      end
      mPre = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        div   = 8 << (2 * mSel[c]);
        tk[c] = (mStart[c] != 0 && (mPre % div) == div - 1) ? 1 : 0;
      end
      for (int c = 0; c < 2; c++) begin
        base  = 1 + 3 * c;
        match = (tk[c] != 0 && mCnt[c] == mCmp[c]) ? 1 : 0;
        clr   = (regWr && regAddr == base && !regWdata[7] && mArm[c] != 0) ? 1 : 0;
        if (clr != 0) mArm[c] = 0;
        else if (regRd && regAddr == base && mFlag[c] != 0) mArm[c] = 1;
        if (match != 0) mFlag[c] = 1;
        else if (clr != 0) mFlag[c] = 0;
        if (standby) mCnt[c] = 0;
        else if (regWr && regAddr == base + 1) mCnt[c] = regWdata;
        else if (match != 0) mCnt[c] = 0;
        else if (tk[c] != 0) mCnt[c] = (mCnt[c] + 1) % 65536;
        if (regWr && regAddr == base + 2) mCmp[c] = regWdata;
        if (regWr && regAddr == base) begin
          mIe[c]  = regWdata[6];
          mSel[c] = regWdata[1:0];
        end
      end
      if (regWr && regAddr == 0) begin
        mStart[0] = regWdata[0];
        mStart[1] = regWdata[1];
      end
      mPre = standby ? 0 : (mPre + 1) % 512;
    end
  end

  function automatic int modelRead(int a);
    case (a)
      0: return mStart[0] | (mStart[1] << 1);
      1, 4: return (mFlag[(a-1)/3] << 7) | (mIe[(a-1)/3] << 6) | mSel[(a-1)/3];
      2, 5: return mCnt[(a-2)/3];
      3, 6: return mCmp[(a-3)/3];
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(int a);
    case (a)
      0: return "R2";
      2, 5: return "R3";
      3, 6: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN && running) begin
      check(tagFor(int'(regAddr)), int'(regRdata), modelRead(int'(regAddr)), "per-cycle read");
      check("R7", int'(irq),
            ((mFlag[1] & mIe[1]) << 1) | (mFlag[0] & mIe[0]), "per-cycle irq");
    end
  end

  // register access tasks, called at a falling edge
  task automatic wrNow(int a, int d);
    regAddr = 3'(a); regWdata = 16'(d); regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic wrReg(int a, int d);
    @(negedge clk);
    wrNow(a, d);
  endtask

  task automatic rdReg(int a, output int v);
    @(negedge clk);
    regAddr = 3'(a); regRd = 1'b1;
    #1 v = int'(regRdata);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // leave the bench at a falling edge just before a tick of channel c
  task automatic waitTick(int c);
    int div;
    div = 8 << (2 * mSel[c]);
    @(negedge clk);
    while ((mPre % div) != div - 1) @(negedge clk);
  endtask

  task automatic finishRun();
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int v, v2;
    rstN = 1'b0; standby = 1'b0; regWr = 1'b0; regRd = 1'b0;
    regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdReg(0, v); check("R1", v, 0, "start after reset");
    rdReg(1, v); check("R1", v, 0, "csr0 after reset");
    rdReg(2, v); check("R1", v, 0, "count0 after reset");
    rdReg(3, v); check("R1", v, 16'hFFFF, "cmp0 after reset");
    rdReg(4, v); check("R1", v, 0, "csr1 after reset");
    rdReg(6, v); check("R1", v, 16'hFFFF, "cmp1 after reset");

    // R5 reserved bits and flag write of 1 ignored
    wrReg(1, 16'hFFFF);
    rdReg(1, v); check("R5", v, 16'h0043, "csr0 reserved bits");
    wrReg(1, 0);
    rdReg(7, v); check("R5", v, 0, "unmapped address");

    // R3 R4 R7 channel 0 at divide-by-8, constant 4
    wrReg(3, 4);
    wrReg(1, 16'h0040);
    wrReg(0, 1);
    repeat (45) @(negedge clk);
    check("R7", int'(irq), 1, "irq0 after match");

    // R6 clear without prior read is ignored
    wrReg(0, 0);
    wrReg(1, 16'h0040);
    check("R6", int'(irq[0]), 1, "flag kept without read");
    rdReg(1, v); check("R6", v, 16'h00C0, "csr0 shows flag");
    wrReg(1, 16'h0040);
    rdReg(1, v); check("R6", v, 16'h0040, "flag cleared after read");
    check("R7", int'(irq[0]), 0, "irq0 low after clear");
    wrReg(1, 16'h00C0);
    rdReg(1, v); check("R6", v, 16'h0040, "writing 1 to flag ignored");

    // R2 stopped channel holds
    rdReg(2, v);
    repeat (50) @(negedge clk);
    rdReg(2, v2); check("R2", v2, v, "stopped count holds");

    // R8 counter write coincides with a tick
    wrReg(3, 16'hFFFF);
    wrReg(0, 1);
    waitTick(0);
    wrNow(2, 16'h1234);
    regAddr = 3'd2; #1;
    check("R8", int'(regRdata), 16'h1234, "write wins over increment");

    // R6 match coincides with a clearing write
    wrReg(3, 5);
    wrReg(2, 5);
    repeat (10) @(negedge clk);
    rdReg(1, v); check("R4", v, 16'h00C0, "match sets flag");
    wrReg(2, 5);
    waitTick(0);
    wrNow(1, 16'h0040);
    rdReg(1, v); check("R6", v, 16'h00C0, "match beats clear");
    rdReg(2, v); check("R4", v, 0, "count wrapped to zero");
    rdReg(1, v);
    wrReg(1, 16'h0040);
    rdReg(1, v); check("R6", v, 16'h0040, "clear after re-read");
    wrReg(0, 0);

    // R9 standby on channel 1 at divide-by-32
    wrReg(4, 16'h0001);
    wrReg(0, 2);
    repeat (100) @(negedge clk);
    @(negedge clk); standby = 1'b1;
    repeat (3) @(negedge clk);
    regAddr = 3'd5; #1;
    check("R9", int'(regRdata), 0, "count1 held in standby");
    regAddr = 3'd6; #1;
    check("R9", int'(regRdata), 16'hFFFF, "cmp1 kept in standby");
    @(negedge clk); standby = 1'b0;
    repeat (31) @(negedge clk);
    regAddr = 3'd5; #1;
    check("R3", int'(regRdata), 0, "no tick before 32 clocks");
    @(negedge clk); #1;
    check("R3", int'(regRdata), 1, "first tick at 32 clocks");

    // R10 channel 1 at divide-by-512, constant 1, enabled
    wrReg(6, 1);
    wrReg(5, 0);
    wrReg(4, 16'h0043);
    repeat (1100) @(negedge clk);
    check("R10", int'(irq), 2, "only channel 1 interrupts");
    rdReg(1, v); check("R10", v, 16'h0040, "channel 0 untouched");

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule